// File: doc/BRIEF.md
# Strobe-Driven Serial Readout Sequencer

This block is the host-side controller for a card-reader chip that is read over two wires. The host drives an active-low strobe line and samples one shared data line. After reset the chip must see a two-pulse opening handshake before it gives any data. The first pulse is a short clear strobe. After a settle gap comes a long stop strobe. Once the handshake is done, every further strobe moves one bit out of the chip. The controller clocks out a 16-bit preamble, stores it, and decodes from its last two bits which kind of chip is fitted and which mode it runs in.

Every low and high phase is timed as a whole number of system-clock cycles. Each count is the nanosecond minimum rounded up, using the cycles-per-microsecond parameter. The default of 250 cycles per microsecond gives these counts: 125 cycles for the clear strobe and for the gap that follows it, 3100 cycles for the stop strobe, and 63 cycles for each half of a read strobe.

A flush command is also available. Once the handshake has finished, it sends a burst of fast strobes without reading anything, so that the chip can be emptied quickly. A `start` pulse begins a read. `busy` stays high for the whole sequence. A single-cycle `done` marks the moment the preamble and the mode code are valid.

Top module: `strobe_rd_seq`

## Requirements
- R1: While reset is asserted and after it is released, `strobe_n` is high and `busy`, `done` and `linked` are low.
- R2: A `start` pulse accepted while idle and not linked drives the clear strobe low for 125 cycles, then holds the line high for 125 cycles, then drives the stop strobe low for 3100 cycles. `linked` rises in the same cycle that the stop strobe ends.
- R3: A read produces exactly 16 read strobes. Each one is a high phase of 63 cycles followed by a low phase of 63 cycles.
- R4: `data_in` is sampled in the final low cycle of each read strobe, so the sample is taken at the rising edge and not after it. A low level is stored as 1 and a high level as 0. The k-th bit read, counting from 0, lands in `preamble[k]`.
- R5: `mode` equals {`preamble[14]`, `preamble[15]`}. The codes are: 0 for the earliest chips (both bits clear), 1 for the later revision (bit 15 only), 2 for the low-voltage chip in its compatible mode (bit 14 only), and 3 for its new mode (both bits set).
- R6: `done` is high for exactly one cycle. It rises in the same cycle that `strobe_n` rises at the end of the last read strobe, with `busy` still high. `busy` is low in the following cycle.
- R7: A `start` accepted while `linked` is high skips the handshake. The first low pulse is then a read strobe of 63 cycles.
- R8: A `start` that arrives while `busy` is high has no effect. The ongoing read still produces its own number of strobes.
- R9: A `flush` accepted while idle and linked, with a count N greater than 0, makes `busy` rise in the next cycle. It then issues N strobes. Each strobe has a high phase and a low phase of max(`flush_half`, 13) cycles, where 13 cycles is 50 ns.
- R10: A `flush` while not linked, or with N = 0, is ignored. `busy` stays low and `strobe_n` stays high.
- R11: A reset in the middle of a sequence returns `strobe_n` high and clears `linked`. The next read begins again with the clear strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a preamble read (accepted only when idle) |
| flush | input | 1 | Request a fast-strobe burst (accepted only when idle and linked) |
| flush_count | input | FLUSH_W | Number of fast strobes in a burst |
| flush_half | input | HALF_W | Cycles per half-period of a fast strobe (clamped to the minimum) |
| data_in | input | 1 | Serial data line from the chip |
| strobe_n | output | 1 | Active-low strobe to the chip |
| busy | output | 1 | High while a handshake, read or flush is in progress |
| done | output | 1 | One-cycle pulse marking that the preamble and mode are valid |
| linked | output | 1 | Opening handshake has completed since reset |
| preamble | output | PRE_BITS | Captured preamble, first bit read in bit 0 |
| mode | output | 2 | Chip mode decoded from the last two preamble bits |

## Verification
A monitor counts every low and high run of `strobe_n` at falling clock edges. Because each phase lasts exactly its rounded cycle count, the widths are compared for equality and not only against a minimum. The chip model changes `data_in` only when it sees a strobe fall. The sampled bit is therefore stable for 63 cycles before the rising edge at which the design takes it. `done` is due in the same cycle as the final rising edge and `busy` drops one cycle later, so those two are checked at consecutive clock edges. After an accepted flush, `busy` is due one cycle after the edge that sampled the request. An ignored request is watched cycle by cycle for 200 cycles.

// File: rtl/strobe_rd_pkg.sv
package strobe_rd_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_CLR_LO, S_GAP_HI, S_STOP_LO,
    S_BIT_HI, S_BIT_LO, S_DONE, S_FL_HI, S_FL_LO
  } seq_state_t;

  typedef enum logic [1:0] {
    CHIP_EARLY = 2'd0,
    CHIP_REVB  = 2'd1,
    CHIP_OLD   = 2'd2,
    CHIP_NEW   = 2'd3
  } chip_mode_t;

  // Minimum width in ns -> clock cycles, rounded up.
  function automatic int ns_to_cycles(input int ns, input int cyc_per_us);
    return (ns * cyc_per_us + 999) / 1000;
  endfunction

  // Mode from the second-to-last and last preamble bits (R5).
  function automatic logic [1:0] mode_of(input logic b_pen, input logic b_last);
    return {b_pen, b_last};
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/strobe_phase_timer.sv
module strobe_phase_timer #(
  parameter int TW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/preamble_shift.sv
module preamble_shift #(
  parameter int PRE_BITS = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                shift_en,
  input  logic                line_in,
  output logic [PRE_BITS-1:0] bits,
  output logic [1:0]          mode
);
  import strobe_rd_pkg::*;

  // Low on the line is a 1; first bit read ends in bit 0 (R4).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        bits <= '0;
    else if (shift_en) bits <= {~line_in, bits[PRE_BITS-1:1]};
  end

  assign mode = mode_of(bits[PRE_BITS-2], bits[PRE_BITS-1]);
endmodule

// File: rtl/strobe_rd_seq.sv
module strobe_rd_seq #(
  parameter int CYC_PER_US = 250,
  parameter int CLR_NS     = 500,
  parameter int GAP_NS     = 500,
  parameter int STOP_NS    = 12400,
  parameter int BIT_NS     = 250,
  parameter int FAST_NS    = 50,
  parameter int PRE_BITS   = 16,
  parameter int FLUSH_W    = 8,
  parameter int HALF_W     = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                flush,
  input  logic [FLUSH_W-1:0]  flush_count,
  input  logic [HALF_W-1:0]   flush_half,
  input  logic                data_in,
  output logic                strobe_n,
  output logic                busy,
  output logic                done,
  output logic                linked,
  output logic [PRE_BITS-1:0] preamble,
  output logic [1:0]          mode
);
  import strobe_rd_pkg::*;

  localparam int CLR_CYC  = ns_to_cycles(CLR_NS,  CYC_PER_US);
  localparam int GAP_CYC  = ns_to_cycles(GAP_NS,  CYC_PER_US);
  localparam int STOP_CYC = ns_to_cycles(STOP_NS, CYC_PER_US);
  localparam int BIT_CYC  = ns_to_cycles(BIT_NS,  CYC_PER_US);
  localparam int FAST_CYC = ns_to_cycles(FAST_NS, CYC_PER_US);
  localparam int MAX_CYC  = max2(max2(CLR_CYC, GAP_CYC), max2(STOP_CYC, BIT_CYC));
  localparam int TW       = max2($clog2(MAX_CYC + 1), HALF_W + 1);
  localparam int BW       = $clog2(PRE_BITS);

  localparam logic [TW-1:0] CLR_M1  = TW'(CLR_CYC - 1);
  localparam logic [TW-1:0] GAP_M1  = TW'(GAP_CYC - 1);
  localparam logic [TW-1:0] STOP_M1 = TW'(STOP_CYC - 1);
  localparam logic [TW-1:0] BIT_M1  = TW'(BIT_CYC - 1);
  localparam logic [TW-1:0] FAST_T  = TW'(FAST_CYC);
  localparam logic [BW-1:0] LAST_BIT = BW'(PRE_BITS - 1);

  seq_state_t         state, nstate;
  logic               expired, t_load;
  logic [TW-1:0]      t_val;
  logic [BW-1:0]      bit_cnt;
  logic [FLUSH_W-1:0] fl_left;
  logic [TW-1:0]      fl_half_q, half_ext, half_eff, fl_half_sel;

  // Named internal events, also watched by the checker.
  logic ev_start_acc, ev_flush_acc, ev_sample, ev_link, ev_fl_edge;

  assign half_ext     = TW'(flush_half);
  assign half_eff     = (half_ext < FAST_T) ? FAST_T : half_ext;
  assign fl_half_sel  = (state == S_IDLE) ? half_eff : fl_half_q;

  assign ev_start_acc = start && (state == S_IDLE);
  assign ev_flush_acc = flush && !start && (state == S_IDLE) && linked &&
                        (flush_count != '0);
  assign ev_sample    = (state == S_BIT_LO) && expired;
  assign ev_link      = (state == S_STOP_LO) && expired;
  assign ev_fl_edge   = (state == S_FL_LO) && expired;

  always_comb begin
    nstate = state;
    unique case (state)
      S_IDLE: begin
        if (ev_start_acc)      nstate = linked ? S_BIT_HI : S_CLR_LO;
        else if (ev_flush_acc) nstate = S_FL_HI;
      end
      S_CLR_LO:  if (expired) nstate = S_GAP_HI;
      S_GAP_HI:  if (expired) nstate = S_STOP_LO;
      S_STOP_LO: if (expired) nstate = S_BIT_HI;
      S_BIT_HI:  if (expired) nstate = S_BIT_LO;
      S_BIT_LO:  if (expired) nstate = (bit_cnt == LAST_BIT) ? S_DONE : S_BIT_HI;
      S_DONE:                 nstate = S_IDLE;
      S_FL_HI:   if (expired) nstate = S_FL_LO;
      S_FL_LO:   if (expired) nstate = (fl_left == FLUSH_W'(1)) ? S_IDLE : S_FL_HI;
      default:                nstate = S_IDLE;
    endcase
  end

  // Every phase change reloads the timer with its own width minus one.
  assign t_load = (nstate != state);
  always_comb begin
    unique case (nstate)
      S_CLR_LO:         t_val = CLR_M1;
      S_GAP_HI:         t_val = GAP_M1;
      S_STOP_LO:        t_val = STOP_M1;
      S_BIT_HI,
      S_BIT_LO:         t_val = BIT_M1;
      S_FL_HI, S_FL_LO: t_val = fl_half_sel - 1'b1;
      default:          t_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      linked    <= 1'b0;
      bit_cnt   <= '0;
      fl_left   <= '0;
      fl_half_q <= '0;
    end else begin
      state <= nstate;
      if (ev_link)           linked  <= 1'b1;
      if (ev_start_acc)      bit_cnt <= '0;
      else if (ev_sample)    bit_cnt <= bit_cnt + 1'b1;
      if (ev_flush_acc) begin
        fl_left   <= flush_count;
        fl_half_q <= half_eff;
      end else if (ev_fl_edge) begin
        fl_left   <= fl_left - 1'b1;
      end
    end
  end

  strobe_phase_timer #(.TW(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (t_load),
    .load_val (t_val),
    .expired  (expired)
  );

  preamble_shift #(.PRE_BITS(PRE_BITS)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (ev_sample),
    .line_in  (data_in),
    .bits     (preamble),
    .mode     (mode)
  );

  assign strobe_n = !(state inside {S_CLR_LO, S_STOP_LO, S_BIT_LO, S_FL_LO});
  assign busy     = (state != S_IDLE);
  assign done     = (state == S_DONE);
endmodule

// File: rtl/strobe_rd_chk.sv
module strobe_rd_chk #(
  parameter int MIN_LO = 13
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic flush,
  input logic strobe_n,
  input logic busy,
  input logic done,
  input logic linked,
  input logic ev_sample,
  input logic ev_link,
  input logic ev_flush_acc
);
  logic [15:0] lo_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               lo_run <= '0;
    else if (strobe_n)        lo_run <= '0;
    else if (lo_run != '1)    lo_run <= lo_run + 1'b1;
  end

  // R1
  idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> strobe_n);

  // R2
  link_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    linked |=> linked);

  // R2
  link_at_stop_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_link |=> (linked && $rose(strobe_n)));

  // R3
  low_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe_n) |-> (lo_run >= 16'(MIN_LO)));

  // R4
  sample_at_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sample |=> $rose(strobe_n));

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  done_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (busy && strobe_n));

  // R6
  done_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  // R9
  flush_needs_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_flush_acc |-> linked);

  // R10
  flush_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !start && !linked && !busy) |=> !busy);
endmodule

bind strobe_rd_seq strobe_rd_chk #(.MIN_LO(FAST_CYC)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start        (start),
  .flush        (flush),
  .strobe_n     (strobe_n),
  .busy         (busy),
  .done         (done),
  .linked       (linked),
  .ev_sample    (ev_sample),
  .ev_link      (ev_link),
  .ev_flush_acc (ev_flush_acc)
);

// File: tb/strobe_rd_seq_tb.sv
`timescale 1ns/1ps
module strobe_rd_seq_tb;
  localparam int E_CLR  = (500 * 250 + 999) / 1000;    // 125
  localparam int E_GAP  = (500 * 250 + 999) / 1000;    // 125
  localparam int E_STOP = (12400 * 250 + 999) / 1000;  // 3100
  localparam int E_BIT  = (250 * 250 + 999) / 1000;    // 63
  localparam int E_FAST = (50 * 250 + 999) / 1000;     // 13

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        flush = 1'b0;
  logic [7:0]  flush_count = '0;
  logic [7:0]  flush_half = '0;
  logic        data_in = 1'b1;
  logic        strobe_n, busy, done, linked;
  logic [15:0] preamble;
  logic [1:0]  mode;

  int checks = 0;
  int fails  = 0;

  strobe_rd_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .flush(flush),
    .flush_count(flush_count), .flush_half(flush_half), .data_in(data_in),
    .strobe_n(strobe_n), .busy(busy), .done(done), .linked(linked),
    .preamble(preamble), .mode(mode)
  );

  always #2 clk = ~clk;

  // Line monitor and chip model: run lengths counted at falling edges.
  int p = 0;
  int run = 0;
  logic prev = 1'b1;
  int lows[256];
  int highs[256];
  logic [15:0] pat = '0;
  int rd_base = -100;

  always @(negedge clk) begin
    if (strobe_n != prev) begin
      if (!strobe_n) begin
        highs[p & 255] = run;
        if ((p - rd_base) >= 0 && (p - rd_base) < 16) data_in = ~pat[p - rd_base];
        else data_in = 1'b1;
        p = p + 1;
      end else begin
        lows[(p - 1) & 255] = run;
      end
      run = 1;
    end else begin
      run = run + 1;
    end
    prev = strobe_n;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic pulse_start();
    start = 1'b1; tick(); start = 1'b0;
  endtask

  task automatic t_reset_state();
    chk(strobe_n == 1'b1, "R1", "strobe_n in reset", strobe_n, 1);
    chk(busy == 1'b0 && done == 1'b0 && linked == 1'b0, "R1", "busy/done/linked in reset",
        {busy, done, linked}, 0);
    rst_n = 1'b1;
    tick(); tick();
    chk(strobe_n == 1'b1 && busy == 1'b0 && linked == 1'b0, "R1", "state after release",
        {strobe_n, busy, linked}, 3'b100);
  endtask

  task automatic t_read(input bit hs, input logic [15:0] pv, input bit poke);
    int base, nexp, guard;
    base = p;
    rd_base = base + (hs ? 2 : 0);
    pat = pv;
    pulse_start();
    if (poke) begin
      repeat (200) tick();
      pulse_start();   // R8: must be ignored
    end
    guard = 0;
    while (!done && guard < 20000) begin tick(); guard++; end
    chk(done == 1'b1, "R6", "done seen", done, 1);
    chk(strobe_n == 1'b1 && busy == 1'b1, "R6", "line high and busy at done",
        {strobe_n, busy}, 2'b11);
    tick();
    chk(done == 1'b0 && busy == 1'b0, "R6", "done/busy one cycle later", {done, busy}, 0);
    nexp = 16 + (hs ? 2 : 0);
    chk(p - base == nexp, poke ? "R8" : "R3", "strobe count", p - base, nexp);
    if (hs) begin
      chk(lows[base & 255] == E_CLR, "R2", "clear strobe low", lows[base & 255], E_CLR);
      chk(highs[(base + 1) & 255] == E_GAP, "R2", "gap high", highs[(base + 1) & 255], E_GAP);
      chk(lows[(base + 1) & 255] == E_STOP, "R2", "stop strobe low",
          lows[(base + 1) & 255], E_STOP);
      chk(linked == 1'b1, "R2", "linked after handshake", linked, 1);
    end else begin
      chk(lows[base & 255] == E_BIT, "R7", "first pulse is a read strobe",
          lows[base & 255], E_BIT);
    end
    for (int k = 0; k < 16; k++) begin
      chk(lows[(rd_base + k) & 255] == E_BIT, "R3", "read low width",
          lows[(rd_base + k) & 255], E_BIT);
      if (hs || k > 0)
        chk(highs[(rd_base + k) & 255] == E_BIT, "R3", "read high width",
            highs[(rd_base + k) & 255], E_BIT);
    end
    chk(preamble == pv, "R4", "preamble", preamble, pv);
    chk(mode == {pv[14], pv[15]}, "R5", "mode code", mode, {pv[14], pv[15]});
  endtask

  task automatic t_flush(input int n, input int half, input int exp_half, input bit run_exp);
    int base, guard, bad;
    base = p;
    flush_count = 8'(n);
    flush_half  = 8'(half);
    flush = 1'b1; tick(); flush = 1'b0;
    if (run_exp) begin
      chk(busy == 1'b1, "R9", "busy after accept", busy, 1);
      guard = 0;
      while (busy && guard < 20000) begin tick(); guard++; end
      tick(); tick();
      chk(p - base == n, "R9", "flush strobe count", p - base, n);
      for (int k = 0; k < n; k++) begin
        chk(lows[(base + k) & 255] == exp_half, "R9", "flush low width",
            lows[(base + k) & 255], exp_half);
        if (k > 0)
          chk(highs[(base + k) & 255] == exp_half, "R9", "flush high width",
              highs[(base + k) & 255], exp_half);
      end
    end else begin
      bad = 0;
      for (int c = 0; c < 200; c++) begin
        if (busy || !strobe_n) bad++;
        tick();
      end
      chk(bad == 0, "R10", "ignored flush activity cycles", bad, 0);
      chk(p - base == 0, "R10", "ignored flush strobes", p - base, 0);
    end
  endtask

  task automatic t_mid_reset();
    pulse_start();
    repeat (500) tick();
    rst_n = 1'b0;
    #1;
    chk(strobe_n == 1'b1 && linked == 1'b0 && busy == 1'b0, "R11", "state after mid reset",
        {strobe_n, linked, busy}, 3'b100);
    tick(); tick();
    rst_n = 1'b1;
    tick(); tick();
    t_read(1'b1, 16'h8000, 1'b0);   // R11: handshake again from the clear strobe
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog all-requirements: actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    tick(); tick();
    t_reset_state();
    t_flush(4, 20, 20, 1'b0);          // R10 not linked
    t_read(1'b1, 16'hC000, 1'b0);      // R2 R3 R4 R5 new mode
    t_read(1'b0, 16'h8000, 1'b1);      // R7 R8 later revision
    t_read(1'b0, 16'h4000, 1'b0);      // R5 compatible mode
    t_read(1'b0, 16'h0000, 1'b0);      // R5 earliest
    t_flush(5, 20, 20, 1'b1);          // R9
    t_flush(3, 3, E_FAST, 1'b1);       // R9 clamp to minimum
    t_flush(0, 20, 20, 1'b0);          // R10 zero count
    t_mid_reset();                     // R11
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule